// File: doc/BRIEF.md
# TDM Frame Sync Monitor

This block watches the frame-sync line of a time-division-multiplexed serial link and checks it against the frame layout it has been programmed with. It runs on a fast engine clock. Its inputs are two single-cycle strobes that mark the rising and falling edges of the bit clock, plus the frame-sync level. Both are already synchronized to the engine clock. Every bit-clock edge counts as one half-bit position. Some programmable number of engine cycles after each edge, the block samples the frame-sync line at that half-bit position.

Once enabled, the block searches for the first frame-sync assertion that lands on the right kind of bit-clock edge. It locks its half-bit position counter to that assertion and from then on judges every frame. A frame is judged from the half-bit position where the sync pulse is expected up to the position just before the next expected one.

The block has three outputs:
- a status bit that says whether the most recent frame carried exactly one correctly placed pulse;
- a one-cycle flag for a frame whose pulse was missing;
- a one-cycle flag for a frame that saw an assertion anywhere else.

Each frame is made of a programmable number of eight-bit slots, with an optional extra frame bit. The expected pulse position is given as a count of half bit-clocks ahead of bit 0 of slot 0. Configuration is expected to be changed only while the block is disabled.

Top module: `tdm_fsync_monitor`

## Requirements
- R1: While `enable` is 0, the block is idle. `sync_good`, `fsync_missing` and `fsync_extra` are 0 from the cycle after `enable` falls, and no frame-sync activity changes them.
- R2: The frame-sync line is sampled `cfg_samp_dly` engine cycles after the cycle of each edge strobe. A value of 0 samples in the strobe cycle itself. A level present only in other cycles is not seen. The offset must be smaller than the spacing of the edge strobes.
- R3: A frame spans 2*(8*`cfg_slots` + `cfg_frame_bit`) half-bit positions. Each rise or fall strobe advances the position by one. `cfg_slots` must be at least 1.
- R4: When `cfg_fsync_inv` is 0 the line is active high. When it is 1 the line is active low. An assertion is an inactive sample followed by an active sample at the next sampling point.
- R5: In search, the block locks only on an assertion whose sampling edge has the type implied by `cfg_fsync_pos`. With bit 0 equal to 0 this is a leading edge; with bit 0 equal to 1 it is a trailing edge. The leading edge is the rise strobe when `cfg_bclk_inv` is 0 and the fall strobe when it is 1. Assertions on the other edge type are ignored.
- R6: The position where the pulse is expected lies `cfg_fsync_pos` half-bits before bit 0 of slot 0. The locking assertion counts as the correctly placed pulse of the first judged frame.
- R7: A frame is judged at its last sampling point, one position before the next expected one. `sync_good` takes its new value in the following cycle: 1 when exactly one assertion fell at the expected position and none elsewhere, else 0.
- R8: `fsync_missing` is a one-cycle pulse, in the same cycle as the `sync_good` update, for a frame with no assertion at the expected position.
- R9: `fsync_extra` is a one-cycle pulse, in the same cycle as the `sync_good` update, for a frame with an assertion at any other position.
- R10: After a missing or extra frame, the block keeps its position counter and does not search again. The next correct frame restores `sync_good` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 = search and track, 0 = idle |
| bclk_rise | input | 1 | One-cycle strobe on a bit-clock rising edge |
| bclk_fall | input | 1 | One-cycle strobe on a bit-clock falling edge |
| fsync_in | input | 1 | Synchronized frame-sync level |
| cfg_fsync_inv | input | 1 | 0 = active-high sync, 1 = active-low sync |
| cfg_bclk_inv | input | 1 | 0 = rising edge leads a bit, 1 = falling edge leads |
| cfg_slots | input | 10 | Number of eight-bit slots per frame |
| cfg_frame_bit | input | 1 | 1 adds one extra bit time per frame |
| cfg_fsync_pos | input | 5 | Expected pulse position, in half-bits before slot 0 |
| cfg_samp_dly | input | 16 | Engine cycles from an edge strobe to its sample |
| sync_good | output | 1 | Most recent judged frame was correct |
| fsync_missing | output | 1 | One-cycle flag: frame lacked its pulse |
| fsync_extra | output | 1 | One-cycle flag: frame had a misplaced pulse |

## Verification
The bench builds the block with its default widths and programs a single slot, which gives frames of 16 or 18 half-bit positions. That keeps a five-frame run short enough to sweep every combination of the two polarities and the frame bit, four pulse positions with both parities, and two sampling offsets. Each combination is run against six stimulus shapes: clean, dropped, added, shifted, wrong-edge-type leading pulse, and dropped final pulse. Separate runs use one-cycle sync glitches to pin down the sampling cycle, and one run feeds pulses while disabled.

// File: rtl/tdm_fsm_pkg.sv
package tdm_fsm_pkg;

  // Monitor phases: idle while disabled, hunting for the first usable
  // assertion, then judging frame after frame.
  typedef enum logic [1:0] {
    MON_IDLE   = 2'd0,
    MON_SEARCH = 2'd1,
    MON_TRACK  = 2'd2
  } mon_state_e;

  // Per-frame verdict gathered by the judge.
  typedef struct packed {
    logic hit;    // assertion seen at the expected position
    logic stray;  // assertion seen anywhere else
  } frame_tally_t;

endpackage

// File: rtl/tdm_sample_timer.sv
// Delays each bit-clock edge by a programmable number of engine cycles and
// raises a one-cycle sample strobe at that point.
module tdm_sample_timer #(
  parameter int SAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              edge_stb,
  input  logic [SAMP_W-1:0] dly,
  output logic              fire
);

  logic [SAMP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (edge_stb) begin
      cnt_q <= dly;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Zero delay samples in the strobe cycle; otherwise the countdown
  // reaching one marks the sampling cycle.
  assign fire = run && ((edge_stb && (dly == '0)) ||
                        (!edge_stb && (cnt_q == SAMP_W'(1))));

endmodule

// File: rtl/tdm_frame_pos.sv
// Half-bit position counter.  Every bit-clock edge advances it by one and it
// wraps at the frame length.  It also remembers whether the latest edge
// started a bit time.
module tdm_frame_pos #(
  parameter int POS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             bclk_inv,
  input  logic [POS_W-1:0] frame_last,
  input  logic             align,
  input  logic [POS_W-1:0] align_pos,
  output logic [POS_W-1:0] smp_pos,
  output logic             smp_lead
);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_next;
  logic             lead_q;
  logic             stb;
  logic             lead_now;

  assign stb      = rise_stb | fall_stb;
  assign lead_now = bclk_inv ? fall_stb : rise_stb;
  assign pos_next = (pos_q >= frame_last) ? '0 : pos_q + 1'b1;

  // A sample taken in the strobe cycle belongs to the new position.
  assign smp_pos  = stb ? pos_next : pos_q;
  assign smp_lead = stb ? lead_now : lead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      lead_q <= 1'b0;
    end else if (!run) begin
      pos_q  <= '0;
      lead_q <= 1'b0;
    end else begin
      if (align) begin
        pos_q <= align_pos;
      end else if (stb) begin
        pos_q <= pos_next;
      end
      if (stb) begin
        lead_q <= lead_now;
      end
    end
  end

endmodule

// File: rtl/tdm_frame_judge.sv
// Search and track control.  It finds the locking assertion, tallies the
// assertions within each frame window and issues the per-frame verdict.
module tdm_frame_judge
  import tdm_fsm_pkg::*;
#(
  parameter int POS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fire,
  input  logic             act,
  input  logic             want_lead,
  input  logic [POS_W-1:0] smp_pos,
  input  logic             smp_lead,
  input  logic [POS_W-1:0] exp_pos,
  input  logic [POS_W-1:0] end_pos,
  output logic             align,
  output logic             good_q,
  output logic             miss_q,
  output logic             extra_q
);

  mon_state_e   state_q;
  frame_tally_t tally_q;
  frame_tally_t tally_n;
  logic         prev_act_q;
  logic         act_edge;
  logic         at_exp;
  logic         at_end;

  assign act_edge = fire && act && !prev_act_q;
  assign at_exp   = (smp_pos == exp_pos);
  assign at_end   = (smp_pos == end_pos);
  assign align    = (state_q == MON_SEARCH) && act_edge && (smp_lead == want_lead);

  always_comb begin
    tally_n       = tally_q;
    tally_n.hit   = tally_q.hit   | (act_edge && at_exp);
    tally_n.stray = tally_q.stray | (act_edge && !at_exp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= MON_IDLE;
      tally_q    <= '0;
      prev_act_q <= 1'b1;
      good_q     <= 1'b0;
      miss_q     <= 1'b0;
      extra_q    <= 1'b0;
    end else if (!run) begin
      state_q    <= MON_IDLE;
      tally_q    <= '0;
      prev_act_q <= 1'b1;
      good_q     <= 1'b0;
      miss_q     <= 1'b0;
      extra_q    <= 1'b0;
    end else begin
      miss_q  <= 1'b0;
      extra_q <= 1'b0;
      if (fire && (state_q != MON_IDLE)) begin
        prev_act_q <= act;
      end
      unique case (state_q)
        MON_IDLE: begin
          state_q <= MON_SEARCH;
        end
        MON_SEARCH: begin
          if (align) begin
            state_q       <= MON_TRACK;
            tally_q.hit   <= 1'b1;
            tally_q.stray <= 1'b0;
          end
        end
        MON_TRACK: begin
          if (fire) begin
            if (at_end) begin
              good_q  <= tally_n.hit && !tally_n.stray;
              miss_q  <= !tally_n.hit;
              extra_q <= tally_n.stray;
              tally_q <= '0;
            end else begin
              tally_q <= tally_n;
            end
          end
        end
        default: begin
          state_q <= MON_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/tdm_fsync_monitor.sv
// Top level: derives the frame geometry from the configuration and links
// the sample timer, the position counter and the frame judge.
module tdm_fsync_monitor #(
  parameter int SLOT_W        = 10,
  parameter int LOC_W         = 5,
  parameter int SAMP_W        = 16,
  parameter int BITS_PER_SLOT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              fsync_in,
  input  logic              cfg_fsync_inv,
  input  logic              cfg_bclk_inv,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              cfg_frame_bit,
  input  logic [LOC_W-1:0]  cfg_fsync_pos,
  input  logic [SAMP_W-1:0] cfg_samp_dly,
  output logic              sync_good,
  output logic              fsync_missing,
  output logic              fsync_extra
);

  localparam int MAX_HALVES = 2 * (BITS_PER_SLOT * ((1 << SLOT_W) - 1) + 1);
  localparam int POS_W      = $clog2(MAX_HALVES + 1);

  logic [POS_W-1:0] frame_len;
  logic [POS_W-1:0] frame_last;
  logic [POS_W-1:0] loc_ext;
  logic [POS_W-1:0] exp_pos;
  logic [POS_W-1:0] end_pos;
  logic [POS_W-1:0] smp_pos;
  logic             smp_lead;
  logic             fire;
  logic             align;
  logic             act;
  logic             want_lead;

  assign frame_len  = POS_W'((32'(cfg_slots) * BITS_PER_SLOT + 32'(cfg_frame_bit)) * 2);
  assign frame_last = frame_len - 1'b1;
  assign loc_ext    = POS_W'(cfg_fsync_pos);
  // Position 0 is bit 0 of slot 0; the pulse sits loc half-bits earlier.
  assign exp_pos    = (loc_ext == '0) ? '0 : frame_len - loc_ext;
  assign end_pos    = (exp_pos == '0) ? frame_last : exp_pos - 1'b1;
  assign act        = fsync_in ^ cfg_fsync_inv;
  assign want_lead  = ~cfg_fsync_pos[0];

  tdm_sample_timer #(.SAMP_W(SAMP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable),
    .edge_stb (bclk_rise | bclk_fall),
    .dly      (cfg_samp_dly),
    .fire     (fire)
  );

  tdm_frame_pos #(.POS_W(POS_W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (enable),
    .rise_stb   (bclk_rise),
    .fall_stb   (bclk_fall),
    .bclk_inv   (cfg_bclk_inv),
    .frame_last (frame_last),
    .align      (align),
    .align_pos  (exp_pos),
    .smp_pos    (smp_pos),
    .smp_lead   (smp_lead)
  );

  tdm_frame_judge #(.POS_W(POS_W)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (enable),
    .fire      (fire),
    .act       (act),
    .want_lead (want_lead),
    .smp_pos   (smp_pos),
    .smp_lead  (smp_lead),
    .exp_pos   (exp_pos),
    .end_pos   (end_pos),
    .align     (align),
    .good_q    (sync_good),
    .miss_q    (fsync_missing),
    .extra_q   (fsync_extra)
  );

endmodule

// File: rtl/tdm_fsync_monitor_chk.sv
module tdm_fsync_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sync_good,
  input logic fsync_missing,
  input logic fsync_extra
);

  AST_IDLE_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !fsync_missing && !fsync_extra); // R1

  AST_IDLE_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sync_good); // R1

  AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_missing |=> !fsync_missing); // R8

  AST_EXTRA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_extra |=> !fsync_extra); // R9

  AST_FLAG_CLEARS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_missing || fsync_extra) |-> !sync_good); // R7

endmodule

bind tdm_fsync_monitor tdm_fsync_monitor_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .sync_good     (sync_good),
  .fsync_missing (fsync_missing),
  .fsync_extra   (fsync_extra)
);

// File: tb/tb_tdm_fsync_monitor.sv
module tb_tdm_fsync_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_CYC   = 4;   // engine cycles per half-bit
  localparam int NF         = 5;   // pulses per run
  localparam int PW         = 2;   // pulse width in half-bits
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        bclk_rise = 1'b0;
  logic        bclk_fall = 1'b0;
  logic        fsync_in = 1'b0;
  logic        cfg_fsync_inv = 1'b0;
  logic        cfg_bclk_inv = 1'b0;
  logic [9:0]  cfg_slots = 10'd1;
  logic        cfg_frame_bit = 1'b0;
  logic [4:0]  cfg_fsync_pos = 5'd0;
  logic [15:0] cfg_samp_dly = 16'd0;
  logic        sync_good;
  logic        fsync_missing;
  logic        fsync_extra;

  int n_checks = 0;
  int n_fail   = 0;
  int n_miss   = 0;
  int n_extra  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_fsync_monitor dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .bclk_rise     (bclk_rise),
    .bclk_fall     (bclk_fall),
    .fsync_in      (fsync_in),
    .cfg_fsync_inv (cfg_fsync_inv),
    .cfg_bclk_inv  (cfg_bclk_inv),
    .cfg_slots     (cfg_slots),
    .cfg_frame_bit (cfg_frame_bit),
    .cfg_fsync_pos (cfg_fsync_pos),
    .cfg_samp_dly  (cfg_samp_dly),
    .sync_good     (sync_good),
    .fsync_missing (fsync_missing),
    .fsync_extra   (fsync_extra)
  );

  always @(negedge clk) begin
    if (fsync_missing) n_miss++;
    if (fsync_extra)   n_extra++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Is the sync line active at half-bit step `step` for stimulus `kind`?
  // 0 clean, 1 drop pulse 2, 2 add a pulse, 3 shift pulse 2,
  // 4 wrong-edge-type pulse before the first one, 5 drop the final pulse.
  function automatic bit pulse_at(int kind, int step, int flen, int loc);
    for (int f = 0; f < NF; f++) begin
      int b = f * flen + flen - loc;
      if (kind == 1 && f == 2) continue;
      if (kind == 5 && f == NF - 1) continue;
      if (kind == 3 && f == 2) b += 2;
      if (step >= b && step < b + PW) return 1'b1;
    end
    if (kind == 2) begin
      int e = 2 * flen + flen - loc + 6;
      if (step >= e && step < e + PW) return 1'b1;
    end
    if (kind == 4) begin
      int e = flen - loc - 3;
      if (step >= e && step < e + PW) return 1'b1;
    end
    return 1'b0;
  endfunction

  // Restart the block with a fresh configuration and play one stimulus.
  // A negative glitch offset holds the level for the whole half-bit.
  task automatic run_scn(input bit en, input int kind, input int glitch);
    int flen;
    int loc;
    int nsteps;
    flen = 2 * (8 * int'(cfg_slots) + int'(cfg_frame_bit));
    loc  = int'(cfg_fsync_pos);
    nsteps = (NF - 1) * flen + flen - loc + flen;
    @(negedge clk);
    enable <= 1'b0;
    fsync_in <= cfg_fsync_inv;
    repeat (2) @(negedge clk);
    n_miss = 0;
    n_extra = 0;
    enable <= en;
    @(negedge clk);
    for (int s = 0; s < nsteps; s++) begin
      bit a = pulse_at(kind, s, flen, loc);
      for (int c = 0; c < STEP_CYC; c++) begin
        bit lvl;
        bit r;
        r = ((s % 2) == 0) != cfg_bclk_inv;
        bclk_rise <= (c == 0) && r;
        bclk_fall <= (c == 0) && !r;
        lvl = (glitch < 0) ? a : (a && (c == glitch));
        fsync_in <= lvl ^ cfg_fsync_inv;
        @(negedge clk);
      end
    end
    bclk_rise <= 1'b0;
    bclk_fall <= 1'b0;
    fsync_in <= cfg_fsync_inv;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int exp_m [6] = '{0, 1, 0, 1, 0, 1};
    int exp_x [6] = '{0, 0, 1, 1, 0, 0};
    int exp_g [6] = '{1, 1, 1, 1, 1, 0};
    int locs  [4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    // Reset state (R1)
    check(!sync_good && !fsync_missing && !fsync_extra, "R1 reset outputs",
          int'(sync_good) + int'(fsync_missing) + int'(fsync_extra), 0);
    rst_n <= 1'b1;
    @(negedge clk);

    // R1: pulses, including a misplaced one, while disabled
    cfg_fsync_pos = 5'd2;
    run_scn(1'b0, 2, -1);
    check(n_miss == 0, "R1 disabled missing", n_miss, 0);
    check(n_extra == 0, "R1 disabled extra", n_extra, 0);
    check(!sync_good, "R1 disabled good", int'(sync_good), 0);

    // Sweep: R3 geometry, R4 sync polarity, R5 edge type, R6..R10 verdicts
    for (int fi = 0; fi < 2; fi++) begin
      for (int bi = 0; bi < 2; bi++) begin
        for (int fb = 0; fb < 2; fb++) begin
          for (int li = 0; li < 4; li++) begin
            cfg_fsync_inv = fi[0];
            cfg_bclk_inv  = bi[0];
            cfg_frame_bit = fb[0];
            cfg_fsync_pos = 5'(locs[li]);
            cfg_samp_dly  = (li[0] ^ fb[0]) ? 16'd3 : 16'd0;
            for (int k = 0; k < 6; k++) begin
              run_scn(1'b1, k, -1);
              check(n_miss == exp_m[k], $sformatf("R8 missing kind%0d inv%0d binv%0d fb%0d loc%0d",
                    k, fi, bi, fb, locs[li]), n_miss, exp_m[k]);
              check(n_extra == exp_x[k], $sformatf("R9 extra kind%0d inv%0d binv%0d fb%0d loc%0d",
                    k, fi, bi, fb, locs[li]), n_extra, exp_x[k]);
              check(int'(sync_good) == exp_g[k], $sformatf("R7 R10 good kind%0d inv%0d bi%0d fb%0d loc%0d",
                    k, fi, bi, fb, locs[li]), int'(sync_good), exp_g[k]);
            end
          end
        end
      end
    end

    // R2: one-cycle glitches, seen only in the sampling cycle
    cfg_fsync_inv = 1'b0;
    cfg_bclk_inv  = 1'b0;
    cfg_frame_bit = 1'b0;
    cfg_fsync_pos = 5'd2;
    cfg_samp_dly  = 16'd2;
    run_scn(1'b1, 0, 2);
    check(int'(sync_good) == 1, "R2 glitch at sample point good", int'(sync_good), 1);
    check(n_miss == 0, "R2 glitch at sample point missing", n_miss, 0);
    run_scn(1'b1, 0, 3);
    check(int'(sync_good) == 0, "R2 glitch after sample point good", int'(sync_good), 0);
    check(n_miss + n_extra == 0, "R2 glitch after sample point events", n_miss + n_extra, 0);
    cfg_samp_dly = 16'd0;
    run_scn(1'b1, 0, 0);
    check(int'(sync_good) == 1, "R2 zero offset good", int'(sync_good), 1);

    // R1: disabling clears the status
    @(negedge clk);
    enable <= 1'b0;
    repeat (2) @(negedge clk);
    check(!sync_good, "R1 good cleared on disable", int'(sync_good), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule